// File: doc/BRIEF.md
# MDIO Management Slave with Interrupt Pulse

This block is the register-access end of a PHY's two-wire management port. The management clock (MDC) and the bidirectional data line (MDIO) are brought into the system clock domain through synchronizers, and each rising MDC edge becomes a one-cycle bit strobe. A state machine parses the serial frame. The frame is a run of preamble ones, the start pair `01`, a two-bit opcode (`10` read, `01` write), a 5-bit PHY address, a 5-bit register address, two turnaround bits and 16 data bits. Every field is sent most significant bit first. On a read whose address matches, the slave leaves the line released for the first turnaround bit, drives 0 for the second, and then drives the register value. On a matching write, the register is updated once the last data bit has arrived.

The register bank has five registers:
- A control word. Bit 10 is the isolate control.
- A fixed capability word. Bit 6 set means frames without preamble are accepted.
- A PHY address register. The address sits in bits 15:11 and is loaded from strap inputs at reset.
- An interrupt enable mask.
- A sticky interrupt status word that clears when it is read.

When an enabled status bit becomes newly set, the block drives a fixed-width active-low pulse on `irq_n`. This pulse is synchronous to the system clock.

The state machine has six states:
- `ST_IDLE` counts consecutive ones. It takes the transition *start-seen* to `ST_START` on a 0 that follows enough ones.
- `ST_START` takes *start-ok* to `ST_OP` on a 1, or *start-bad* back to `ST_IDLE`.
- `ST_OP` takes *op-valid* to `ST_ADDR` after two bits, or *op-bad* back to `ST_IDLE`.
- `ST_ADDR` takes *addr-done* to `ST_TA` after ten bits.
- `ST_TA` takes *ta-done* to `ST_DATA` after two bits.
- `ST_DATA` takes *data-done* back to `ST_IDLE` after sixteen bits.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: Reset state.
  - While reset is held and after it is released, `mdio_oe` is 0 and `irq_n` is 1.
  - Register 19h reads as `{strap_addr, 11'b0}`.
  - `isolate` is 1 exactly when `strap_addr` was 00000 at reset.
- R2: Preamble rule.
  - After reset, a frame is decoded only once at least 32 consecutive ones have preceded its start bit.
  - Later frames need only one or more ones before the start bit.
- R3: Read timing.
  - On a read frame (opcode `10`) whose address matches, `mdio_oe` stays 0 during the first turnaround bit.
  - The slave then drives 0 for the second turnaround bit.
  - It then drives the 16 register bits MSB first, for 17 driven bit periods in all.
  - `mdio_oe` changes only in the cycle after a detected MDC rising edge.
- R4: Writable registers.
  - A matching write frame (opcode `01`) to register 00h, 19h (address in bits 15:11, other bits read 0) or 1Dh is read back unchanged.
  - Register 1Dh holds the interrupt enable mask, where 1 means enabled.
- R5: Capability word.
  - Register 01h reads the capability word, which is 16'h7849 by default and always has bit 6 set.
  - Writes to 01h have no effect.
- R6: Address mismatch.
  - A frame whose PHY address differs from the current address is neither driven nor written.
- R7: Invalid frames.
  - A frame with start bits other than `01`, or an opcode of `00` or `11`, is abandoned: no drive and no write.
- R8: Isolate.
  - The isolate bit (register 00h, bit 10) changes only by a write to register 00h.
  - Rewriting the PHY address leaves it unchanged.
  - The `isolate` output is that bit OR'd with (current PHY address == 0).
- R9: Interrupt status.
  - Register 1Eh sets a bit for each `irq_event` bit that is high, whether or not the bit is enabled.
  - Set bits stay set until 1Eh is read.
  - A read returns the pre-clear value and then clears the register.
- R10: Interrupt pulse.
  - `irq_n` goes low for exactly `PULSE_CYC` clock cycles (2 by default), starting one cycle after an event sets a status bit that was clear and is enabled.
  - Masked events and events on bits already set produce no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdc | input | 1 | Management clock, asynchronous |
| mdio_in | input | 1 | Sampled level of the management data line |
| mdio_out | output | 1 | Value driven onto the data line when enabled |
| mdio_oe | output | 1 | Drive enable for the data line |
| strap_addr | input | 5 | PHY address straps, captured during reset |
| irq_event | input | IRQ_W | Interrupt source strobes, one per status bit |
| irq_n | output | 1 | Active-low interrupt pulse |
| isolate | output | 1 | Isolate mode indication |

## Verification
The assertions check the following on every cycle:
- The data-line drive only ever switches right after an MDC edge strobe.
- Status bits never drop without a status read.
- The isolate bit never moves without a control write.
- Each falling edge of `irq_n` has an enabled event behind it and is at least two cycles wide.

Only the bench's scenarios can show:
- That frame fields are decoded and answered with the right bits.
- That frames lacking the first full preamble, frames with wrong addresses and frames with bad start or opcode leave both the line and the registers untouched.
- That the pulse width and the clear-on-read ordering match a behavioural model cycle by cycle.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int PHY_W     = 5;
    localparam int REG_W     = 5;
    localparam int DATA_W    = 16;
    localparam int ADDR_BITS = PHY_W + REG_W;
    localparam int PRE_LEN   = 32;
    localparam int ONES_W    = $clog2(PRE_LEN + 1);
    localparam int CNT_W     = $clog2(DATA_W);

    localparam logic [REG_W-1:0] REG_CTRL  = 5'h00;
    localparam logic [REG_W-1:0] REG_STAT  = 5'h01;
    localparam logic [REG_W-1:0] REG_PHYAD = 5'h19;
    localparam logic [REG_W-1:0] REG_IMASK = 5'h1D;
    localparam logic [REG_W-1:0] REG_ISTAT = 5'h1E;

    localparam int ISO_BIT     = 10;
    localparam int NOPRE_BIT   = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_OP,
        ST_ADDR,
        ST_TA,
        ST_DATA
    } mdio_state_e;
endpackage

// File: rtl/mdio_sync.sv
module mdio_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mdc_in,
    input  logic mdio_in,
    output logic bit_stb,
    output logic bit_val
);
    logic [STAGES-1:0] mdc_pipe;
    logic [STAGES-1:0] dio_pipe;
    logic              mdc_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdc_pipe <= '0;
            dio_pipe <= '1;
            mdc_prev <= 1'b0;
        end else begin
            mdc_pipe <= {mdc_pipe[STAGES-2:0], mdc_in};
            dio_pipe <= {dio_pipe[STAGES-2:0], mdio_in};
            mdc_prev <= mdc_pipe[STAGES-1];
        end
    end

    assign bit_stb = mdc_pipe[STAGES-1] & ~mdc_prev;
    assign bit_val = dio_pipe[STAGES-1];
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              bit_val,
    input  logic [PHY_W-1:0]  my_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rd_stb,
    output logic [REG_W-1:0]  rd_addr,
    output logic              wr_stb,
    output logic [REG_W-1:0]  wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              mdio_oe,
    output logic              mdio_out
);
    mdio_state_e       state, state_n;
    logic [ONES_W-1:0] ones_cnt;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-2:0] sh;
    logic [DATA_W-1:0] rd_sh;
    logic [REG_W-1:0]  reg_q;
    logic              pre_seen, is_read, hit;
    logic              ones_ok, op_rd, op_wr;
    logic              last_op, last_addr, last_ta, last_data;
    logic              addr_match;

    assign ones_ok    = pre_seen ? (ones_cnt != '0) : (ones_cnt == ONES_W'(PRE_LEN));
    assign op_rd      = sh[0] & ~bit_val;
    assign op_wr      = ~sh[0] & bit_val;
    assign last_op    = (state == ST_OP)   && (bit_cnt == CNT_W'(1));
    assign last_addr  = (state == ST_ADDR) && (bit_cnt == CNT_W'(ADDR_BITS - 1));
    assign last_ta    = (state == ST_TA)   && (bit_cnt == CNT_W'(1));
    assign last_data  = (state == ST_DATA) && (bit_cnt == CNT_W'(DATA_W - 1));
    assign rd_addr    = {sh[REG_W-2:0], bit_val};
    assign addr_match = (sh[ADDR_BITS-2:REG_W-1] == my_addr);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // transitions
    always_comb begin
        state_n = state;
        if (bit_stb) begin
            unique case (state)
                ST_IDLE:  if (!bit_val && ones_ok) state_n = ST_START;
                ST_START: state_n = bit_val ? ST_OP : ST_IDLE;
                ST_OP:    if (last_op) state_n = (op_rd || op_wr) ? ST_ADDR : ST_IDLE;
                ST_ADDR:  if (last_addr) state_n = ST_TA;
                ST_TA:    if (last_ta) state_n = ST_DATA;
                ST_DATA:  if (last_data) state_n = ST_IDLE;
                default:  state_n = ST_IDLE;
            endcase
        end
    end

    // frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ones_cnt <= '0;
            pre_seen <= 1'b0;
            bit_cnt  <= '0;
            sh       <= '0;
            rd_sh    <= '0;
            reg_q    <= '0;
            is_read  <= 1'b0;
            hit      <= 1'b0;
        end else if (bit_stb) begin
            sh      <= {sh[DATA_W-3:0], bit_val};
            bit_cnt <= (state_n != state) ? '0 : bit_cnt + 1'b1;
            if (state == ST_IDLE && bit_val)
                ones_cnt <= (ones_cnt == ONES_W'(PRE_LEN)) ? ones_cnt : ones_cnt + 1'b1;
            else
                ones_cnt <= '0;
            if (state == ST_IDLE && !bit_val && ones_cnt == ONES_W'(PRE_LEN))
                pre_seen <= 1'b1;
            if (last_op)
                is_read <= op_rd;
            if (last_addr) begin
                hit   <= addr_match;
                reg_q <= rd_addr;
                rd_sh <= rd_data;
            end
            if (state == ST_DATA)
                rd_sh <= {rd_sh[DATA_W-2:0], 1'b0};
        end
    end

    assign rd_stb  = bit_stb && last_addr && is_read && addr_match;
    assign wr_stb  = bit_stb && last_data && !is_read && hit;
    assign wr_addr = reg_q;
    assign wr_data = {sh, bit_val};

    // line outputs
    always_comb begin
        mdio_oe  = 1'b0;
        mdio_out = 1'b0;
        if (is_read && hit) begin
            if (last_ta) begin
                mdio_oe = 1'b1;
            end else if (state == ST_DATA) begin
                mdio_oe  = 1'b1;
                mdio_out = rd_sh[DATA_W-1];
            end
        end
    end
endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile
    import mdio_pkg::*;
#(
    parameter int                IRQ_W       = 16,
    parameter logic [DATA_W-1:0] STATUS_CAPS = 16'h7849
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PHY_W-1:0]  strap_addr,
    input  logic              rd_stb,
    input  logic [REG_W-1:0]  rd_addr,
    input  logic              wr_stb,
    input  logic [REG_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IRQ_W-1:0]  irq_event,
    output logic [DATA_W-1:0] rd_data,
    output logic [PHY_W-1:0]  my_addr,
    output logic              iso_bit,
    output logic              isolate,
    output logic [IRQ_W-1:0]  imask,
    output logic [IRQ_W-1:0]  istat,
    output logic              irq_trig,
    output logic              irq_cancel
);
    logic [DATA_W-1:0] ctrl_q;
    logic [PHY_W-1:0]  phy_q;
    logic [IRQ_W-1:0]  imask_q, istat_q;

    assign irq_cancel = rd_stb && (rd_addr == REG_ISTAT);
    assign irq_trig   = |(irq_event & ~istat_q & imask_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q          <= '0;
            ctrl_q[ISO_BIT] <= (strap_addr == '0);
            phy_q           <= strap_addr;
            imask_q         <= '0;
            istat_q         <= '0;
        end else begin
            istat_q <= (irq_cancel ? '0 : istat_q) | irq_event;
            if (wr_stb) begin
                unique case (wr_addr)
                    REG_CTRL:  ctrl_q  <= wr_data;
                    REG_PHYAD: phy_q   <= wr_data[DATA_W-1 -: PHY_W];
                    REG_IMASK: imask_q <= wr_data[IRQ_W-1:0];
                    default:   ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (rd_addr)
            REG_CTRL:  rd_data = ctrl_q;
            REG_STAT:  rd_data = STATUS_CAPS | (DATA_W'(1) << NOPRE_BIT);
            REG_PHYAD: rd_data = {phy_q, {(DATA_W-PHY_W){1'b0}}};
            REG_IMASK: rd_data = DATA_W'(imask_q);
            REG_ISTAT: rd_data = DATA_W'(istat_q);
            default:   rd_data = '0;
        endcase
    end

    assign my_addr = phy_q;
    assign iso_bit = ctrl_q[ISO_BIT];
    assign isolate = ctrl_q[ISO_BIT] | (phy_q == '0);
    assign imask   = imask_q;
    assign istat   = istat_q;
endmodule

// File: rtl/mdio_irq_pulse.sv
module mdio_irq_pulse #(
    parameter int PULSE_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic cancel,
    output logic irq_n
);
    localparam int CW = $clog2(PULSE_CYC + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (trig)       cnt <= CW'(PULSE_CYC);
        else if (cancel)     cnt <= '0;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign irq_n = (cnt == '0);
endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
    import mdio_pkg::*;
#(
    parameter int                IRQ_W       = 16,
    parameter int                PULSE_CYC   = 2,
    parameter int                SYNC_STAGES = 2,
    parameter logic [DATA_W-1:0] STATUS_CAPS = 16'h7849
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mdc,
    input  logic             mdio_in,
    output logic             mdio_out,
    output logic             mdio_oe,
    input  logic [PHY_W-1:0] strap_addr,
    input  logic [IRQ_W-1:0] irq_event,
    output logic             irq_n,
    output logic             isolate
);
    logic              bit_stb, bit_val;
    logic              rd_stb, wr_stb;
    logic [REG_W-1:0]  rd_addr, wr_addr;
    logic [DATA_W-1:0] rd_data, wr_data;
    logic [PHY_W-1:0]  my_addr;
    logic              iso_bit, irq_trig, irq_cancel;
    logic [IRQ_W-1:0]  imask, istat;

    mdio_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .mdc_in(mdc), .mdio_in(mdio_in),
        .bit_stb(bit_stb), .bit_val(bit_val)
    );

    mdio_frame_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_val(bit_val),
        .my_addr(my_addr), .rd_data(rd_data),
        .rd_stb(rd_stb), .rd_addr(rd_addr),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .mdio_oe(mdio_oe), .mdio_out(mdio_out)
    );

    mdio_regfile #(.IRQ_W(IRQ_W), .STATUS_CAPS(STATUS_CAPS)) u_regs (
        .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr),
        .rd_stb(rd_stb), .rd_addr(rd_addr),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .irq_event(irq_event), .rd_data(rd_data), .my_addr(my_addr),
        .iso_bit(iso_bit), .isolate(isolate), .imask(imask), .istat(istat),
        .irq_trig(irq_trig), .irq_cancel(irq_cancel)
    );

    mdio_irq_pulse #(.PULSE_CYC(PULSE_CYC)) u_irq (
        .clk(clk), .rst_n(rst_n), .trig(irq_trig), .cancel(irq_cancel),
        .irq_n(irq_n)
    );
endmodule

// File: rtl/mdio_mgmt_slave_chk.sv
module mdio_mgmt_slave_chk
    import mdio_pkg::*;
#(
    parameter int IRQ_W     = 16,
    parameter int PULSE_CYC = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_stb,
    input logic             mdio_oe,
    input logic             irq_n,
    input logic [IRQ_W-1:0] irq_event,
    input logic [IRQ_W-1:0] imask,
    input logic [IRQ_W-1:0] istat,
    input logic             rd_stb,
    input logic [REG_W-1:0] rd_addr,
    input logic             wr_stb,
    input logic [REG_W-1:0] wr_addr,
    input logic             iso_bit
);
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!mdio_oe && irq_n));

    p_oe_rise_on_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> $past(bit_stb));

    p_oe_fall_on_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mdio_oe) |-> $past(bit_stb));

    p_iso_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && wr_addr == REG_CTRL) |=> $stable(iso_bit));

    p_status_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb && rd_addr == REG_ISTAT) |=> ((istat & $past(istat)) == $past(istat)));

    p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> $past(|(irq_event & imask)));

    generate
        if (PULSE_CYC >= 2) begin : g_width
            p_irq_width_r10: assert property (@(posedge clk) disable iff (!rst_n)
                ($fell(irq_n) && !(rd_stb && rd_addr == REG_ISTAT)) |=> !irq_n);
        end
    endgenerate
endmodule

bind mdio_mgmt_slave mdio_mgmt_slave_chk #(.IRQ_W(IRQ_W), .PULSE_CYC(PULSE_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .mdio_oe(mdio_oe),
    .irq_n(irq_n), .irq_event(irq_event), .imask(imask), .istat(istat),
    .rd_stb(rd_stb), .rd_addr(rd_addr), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .iso_bit(iso_bit)
);

// File: tb/mdio_mgmt_slave_bench.sv
`timescale 1ns/1ps
module mdio_mgmt_slave_bench;
    localparam int PULSE = 2;
    localparam logic [15:0] CAPS = 16'h7849;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        mdc, m_en, m_bit;
    logic [4:0]  strap;
    logic [15:0] irq_event;
    logic        mdio_out, mdio_oe, irq_n, isolate;
    logic        mdio_line;

    int checks = 0, failures = 0;
    bit done = 0;

    // behavioural interrupt model
    logic [15:0] m_stat, m_mask;
    int          m_cnt;

    always #10 clk = ~clk;

    assign mdio_line = mdio_oe ? mdio_out : (m_en ? m_bit : 1'b1);

    mdio_mgmt_slave u_mdio_mgmt_slave (
        .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_in(mdio_line),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .strap_addr(strap),
        .irq_event(irq_event), .irq_n(irq_n), .isolate(isolate)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_stat = '0; m_cnt = 0;
        end else begin
            if (|(irq_event & ~m_stat & m_mask)) m_cnt = PULSE;
            else if (m_cnt > 0) m_cnt = m_cnt - 1;
            m_stat = m_stat | irq_event;
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (irq_n !== (m_cnt == 0)) begin
                failures++;
                $display("FAIL R10 irq_n per-cycle act=%b exp=%b", irq_n, (m_cnt == 0));
            end
            checks++;
            if (mdio_oe && m_en) begin
                failures++;
                $display("FAIL R6 line contention act=%b exp=%b", mdio_oe, 1'b0);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic mbit(input logic en, input logic b, output logic smp, output logic oe_seen);
        m_en = en; m_bit = b; mdc = 1'b0;
        repeat (10) @(negedge clk);
        smp = mdio_line; oe_seen = mdio_oe;
        mdc = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic frame(input int pre, input logic [1:0] st, input logic [1:0] op,
                         input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] wd,
                         output logic [15:0] rd, output int drove, output logic ta1);
        logic s, o;
        logic [13:0] hdr;
        rd = '0; drove = 0; ta1 = 1'b0;
        for (int i = 0; i < pre; i++) mbit(1'b1, 1'b1, s, o);
        hdr = {st, op, phy, rg};
        for (int i = 13; i >= 0; i--) mbit(1'b1, hdr[i], s, o);
        mbit(1'b0, 1'b1, s, o); ta1 = o; if (o) drove++;
        mbit(1'b0, 1'b1, s, o); if (o) drove++;
        for (int i = 15; i >= 0; i--) begin
            if (op == 2'b10) begin
                mbit(1'b0, 1'b1, s, o);
                rd = {rd[14:0], s};
            end else begin
                mbit(1'b1, wd[i], s, o);
            end
            if (o) drove++;
        end
        m_en = 1'b0;
    endtask

    task automatic rd_reg(input int pre, input logic [4:0] phy, input logic [4:0] rg,
                          output logic [15:0] v, output int drove, output logic ta1);
        frame(pre, 2'b01, 2'b10, phy, rg, 16'h0, v, drove, ta1);
    endtask

    task automatic wr_reg(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] v);
        logic [15:0] d; int n; logic t;
        frame(1, 2'b01, 2'b01, phy, rg, v, d, n, t);
    endtask

    task automatic event_pulse(input logic [15:0] v, input int exp_low, input string tag);
        int low = 0;
        irq_event = v;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (!irq_n) low++;
            irq_event = '0;
        end
        chk(tag, low, exp_low);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] v; int n; logic t;
        rst_n = 1'b0; mdc = 1'b0; m_en = 1'b0; m_bit = 1'b1;
        strap = 5'h00; irq_event = '0; m_mask = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // session 1: address strap 0
        chk("R1 isolate with zero strap", isolate, 1'b1);
        chk("R1 oe after reset", mdio_oe, 1'b0);
        rd_reg(32, 5'h00, 5'h00, v, n, t);
        chk("R8 ctrl isolate bit at reset", v, 16'h0400);
        chk("R3 driven bit periods", n, 17);
        chk("R3 first turnaround released", t, 1'b0);

        // R7: invalid opcode 00 write of zeros to ctrl must not land
        frame(1, 2'b01, 2'b00, 5'h00, 5'h00, 16'h0000, v, n, t);
        chk("R7 opcode 00 no drive", n, 0);
        frame(1, 2'b01, 2'b11, 5'h00, 5'h00, 16'h0000, v, n, t);
        chk("R7 opcode 11 no drive", n, 0);
        frame(1, 2'b00, 2'b10, 5'h00, 5'h00, 16'h0000, v, n, t);
        chk("R7 bad start no drive", n, 0);
        rd_reg(1, 5'h00, 5'h00, v, n, t);
        chk("R7 ctrl unchanged after invalid frames", v, 16'h0400);

        wr_reg(5'h00, 5'h19, 16'h2800);
        rd_reg(1, 5'h05, 5'h19, v, n, t);
        chk("R4 phy address readback", v, 16'h2800);
        rd_reg(1, 5'h05, 5'h00, v, n, t);
        chk("R8 isolate bit kept after address write", v, 16'h0400);
        chk("R8 isolate output after address write", isolate, 1'b1);
        wr_reg(5'h05, 5'h00, 16'h0000);
        repeat (4) @(negedge clk);
        chk("R8 isolate cleared by ctrl write", isolate, 1'b0);
        wr_reg(5'h05, 5'h19, 16'h0000);
        repeat (4) @(negedge clk);
        chk("R8 isolate forced by address zero", isolate, 1'b1);
        rd_reg(1, 5'h00, 5'h00, v, n, t);
        chk("R8 ctrl bit still clear", v, 16'h0000);

        // session 2: address strap 0x0A
        @(negedge clk);
        rst_n = 1'b0; strap = 5'h0A; m_mask = '0;
        repeat (5) @(negedge clk);
        chk("R1 oe during reset", mdio_oe, 1'b0);
        chk("R1 irq_n during reset", irq_n, 1'b1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 isolate with nonzero strap", isolate, 1'b0);
        chk("R1 irq_n idle", irq_n, 1'b1);

        rd_reg(1, 5'h0A, 5'h19, v, n, t);
        chk("R2 short preamble after reset ignored", n, 0);
        rd_reg(32, 5'h0A, 5'h19, v, n, t);
        chk("R1 strap address readback", v, 16'h5000);
        chk("R3 driven bit periods", n, 17);
        rd_reg(1, 5'h0A, 5'h19, v, n, t);
        chk("R2 suppressed preamble accepted", v, 16'h5000);

        rd_reg(1, 5'h0A, 5'h01, v, n, t);
        chk("R5 capability word", v, CAPS);
        wr_reg(5'h0A, 5'h01, 16'h0000);
        rd_reg(1, 5'h0A, 5'h01, v, n, t);
        chk("R5 capability word after write", v, CAPS);

        rd_reg(1, 5'h0B, 5'h00, v, n, t);
        chk("R6 mismatched read not driven", n, 0);
        wr_reg(5'h0B, 5'h1D, 16'hFFFF);
        rd_reg(1, 5'h0A, 5'h1D, v, n, t);
        chk("R6 mismatched write ignored", v, 16'h0000);

        wr_reg(5'h0A, 5'h00, 16'h1234);
        rd_reg(1, 5'h0A, 5'h00, v, n, t);
        chk("R4 ctrl readback", v, 16'h1234);
        wr_reg(5'h0A, 5'h1D, 16'h0005);
        m_mask = 16'h0005;
        rd_reg(1, 5'h0A, 5'h1D, v, n, t);
        chk("R4 mask readback", v, 16'h0005);

        event_pulse(16'h0001, PULSE, "R10 enabled event pulse width");
        event_pulse(16'h0002, 0, "R10 masked event no pulse");
        event_pulse(16'h0001, 0, "R10 already-set bit no pulse");
        rd_reg(1, 5'h0A, 5'h1E, v, n, t);
        m_stat = '0;
        chk("R9 status read value", v, 16'h0003);
        rd_reg(1, 5'h0A, 5'h1E, v, n, t);
        chk("R9 status cleared by read", v, 16'h0000);
        event_pulse(16'h0004, PULSE, "R10 pulse after clear");
        rd_reg(1, 5'h0A, 5'h1E, v, n, t);
        m_stat = '0;
        chk("R9 second status read", v, 16'h0004);

        repeat (5) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule